// File: doc/BRIEF.md
# Load/Store-Multiple Micro-Op Sequencer

The sequencer accepts one decoded block-transfer instruction at a time and breaks it into an ordered stream of micro-operations. The stream leaves one micro-op per cycle over a valid/ready handshake. The instruction arrives as a register-list bitmask, a base register index and five flags: load versus store, address increment versus decrement, before versus after addressing, base writeback, and user bank.

Every micro-op carries the following fields:
- an opcode;
- a destination/data register index and a source/base register index;
- an unsigned offset magnitude with a direction bit;
- a user-bank flag;
- control-transfer and return hints;
- a last marker.

The block does not execute micro-ops and does not access memory. It only fixes their order. The base register is updated only after every memory access has been issued. For a load with writeback, the final loaded value is parked in a temporary register and moved into its real destination only after the base update. A fault at any memory micro-op therefore leaves the base register unchanged.

Register indices 0 to 15 name architectural registers. Index 15 is the program counter and index 13 is the stack pointer. Index 16 is temporary 0 and index 17 is temporary 1.

Top module: `lsm_uop_seq`

## Requirements
- R1: `req_ready` is high exactly when no sequence is in progress, and `uop_valid` is never high at the same time. A request is taken on a cycle with `req_valid` and `req_ready` both high. While `uop_valid` is high and `uop_ready` is low, every micro-op output holds its value.
- R2: An empty register list produces exactly one micro-op with `uop_last`=1. That micro-op is the base copy of R4.
- R3: For a non-empty list holding N registers, the sequence has N+1 micro-ops. Writeback adds 2 more for a load and 1 more for a store. `uop_last` is high on the final micro-op only.
- R4: The first micro-op is an add-immediate (opcode 0) with ra=16, rb=base, offset 0 and up=1.
- R5: The memory micro-ops visit the set bits from lowest to highest, each with rb=16 and up=increment flag.
  - For increment, the first offset is 4 with before-addressing and 0 otherwise, and it rises by 4 per register.
  - For decrement, the first offset is 4N, less 4 with after-addressing, and it falls by 4 per register.
  - Opcode encoding: add-imm 0, sub-imm 1, load 2, load-with-exception-return 3, store 4, move 5, move-with-exception-return 6.
- R6: For a load with writeback, the highest listed register is loaded into ra=17 (temporary 1) instead of its own index.
- R7: With writeback, one add-imm (increment) or sub-imm (decrement) follows all memory micro-ops, with ra=rb=base, offset 4N and up=increment flag. No memory micro-op follows it within the sequence.
- R8: For a load with writeback, the last micro-op moves rb=17 into ra=the highest listed register. It uses opcode 6 with ra=15 when that register is 15 and exception return applies; otherwise it uses opcode 5.
- R9: With the user flag set and bit 15 clear, every data-register micro-op (load, store, move) has `uop_usr`=1. In every other case `uop_usr`=0. The user flag with bit 15 set selects exception return.
- R10: A load without writeback, with exception return, loads register 15 with opcode 3.
- R11: A move (opcode 5) into register 15 has `uop_ctrl`=1. It also has `uop_ret`=1 when the base is 13. All other micro-ops have both hints at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Instruction offered |
| req_ready | output | 1 | Sequencer idle, instruction can be taken |
| req_list | input | NREGS | Register-list bitmask |
| req_base | input | RIW | Base register index |
| req_load | input | 1 | 1 = load, 0 = store |
| req_incr | input | 1 | 1 = addresses increase, 0 = decrease |
| req_before | input | 1 | 1 = adjust address before first access |
| req_wb | input | 1 | Base writeback requested |
| req_user | input | 1 | User-bank / exception-return flag |
| uop_valid | output | 1 | Micro-op present |
| uop_ready | input | 1 | Consumer takes the micro-op |
| uop_opc | output | 3 | Micro-op opcode |
| uop_ra | output | IDXW | Destination or data register index |
| uop_rb | output | IDXW | Source or address base register index |
| uop_off | output | OFFW | Offset magnitude |
| uop_up | output | 1 | Offset direction, 1 = add |
| uop_usr | output | 1 | Data register taken from user bank |
| uop_ctrl | output | 1 | Indirect conditional control-transfer hint |
| uop_ret | output | 1 | Return hint |
| uop_last | output | 1 | Final micro-op of the instruction |

## Verification
The assertions check the properties that hold on every cycle:
- the idle/busy exclusivity of the two handshakes;
- the output hold under backpressure;
- the shape of the first micro-op after an accept;
- the return to idle after a last marker;
- the absence of any memory micro-op after the base update;
- the hint flags appearing only on program-counter moves.

Only the bench scenarios show the data-dependent content: the exact offsets for each addressing mode, the temporary-1 redirection, the opcode chosen for exception return, and the total micro-op count. The bench compares every micro-op the design hands over against a queue built from the rules, under randomized consumer backpressure.

// File: rtl/lsm_pkg.sv
package lsm_pkg;

    typedef enum logic [2:0] {
        OP_ADDI    = 3'd0,
        OP_SUBI    = 3'd1,
        OP_LOAD    = 3'd2,
        OP_LOADRET = 3'd3,
        OP_STORE   = 3'd4,
        OP_MOV     = 3'd5,
        OP_MOVRET  = 3'd6
    } uop_op_e;

    typedef enum logic [2:0] {
        PH_IDLE = 3'd0,
        PH_COPY = 3'd1,
        PH_MEM  = 3'd2,
        PH_WB   = 3'd3,
        PH_MOVE = 3'd4
    } phase_e;

endpackage

// File: rtl/lsm_popcnt.sv
module lsm_popcnt #(
    parameter int N  = 16,
    parameter int CW = $clog2(N + 1)
) (
    input  logic [N-1:0]  bits_i,
    output logic [CW-1:0] cnt_o
);
    logic [CW-1:0] acc [0:N];

    assign acc[0] = '0;

    for (genvar i = 0; i < N; i++) begin : g_sum
        assign acc[i+1] = acc[i] + CW'(bits_i[i]);
    end

    assign cnt_o = acc[N];
endmodule

// File: rtl/lsm_lowbit.sv
module lsm_lowbit #(
    parameter int N  = 16,
    parameter int IW = $clog2(N)
) (
    input  logic [N-1:0]  mask_i,
    output logic [IW-1:0] idx_o,
    output logic [N-1:0]  rest_o
);
    always_comb begin
        idx_o = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (mask_i[i]) idx_o = IW'(i);
        end
    end

    assign rest_o = mask_i & (mask_i - N'(1));
endmodule

// File: rtl/lsm_uop_seq.sv
module lsm_uop_seq
    import lsm_pkg::*;
#(
    parameter int NREGS  = 16,
    parameter int PC_IDX = 15,
    parameter int SP_IDX = 13,
    parameter int RIW    = $clog2(NREGS),
    parameter int IDXW   = RIW + 1,
    parameter int OFFW   = $clog2(NREGS * 4) + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [NREGS-1:0] req_list,
    input  logic [RIW-1:0]   req_base,
    input  logic             req_load,
    input  logic             req_incr,
    input  logic             req_before,
    input  logic             req_wb,
    input  logic             req_user,
    output logic             uop_valid,
    input  logic             uop_ready,
    output logic [2:0]       uop_opc,
    output logic [IDXW-1:0]  uop_ra,
    output logic [IDXW-1:0]  uop_rb,
    output logic [OFFW-1:0]  uop_off,
    output logic             uop_up,
    output logic             uop_usr,
    output logic             uop_ctrl,
    output logic             uop_ret,
    output logic             uop_last
);
    localparam int CNTW = $clog2(NREGS + 1);
    localparam logic [IDXW-1:0] TMP0 = IDXW'(NREGS);
    localparam logic [IDXW-1:0] TMP1 = IDXW'(NREGS + 1);
    localparam logic [RIW-1:0]  PCR  = RIW'(PC_IDX);
    localparam logic [RIW-1:0]  SPR  = RIW'(SP_IDX);
    localparam logic [OFFW-1:0] STEP = OFFW'(4);

    typedef struct packed {
        phase_e           ph;
        logic [NREGS-1:0] mask;
        logic [RIW-1:0]   base;
        logic             ld;
        logic             incr;
        logic             wb;
        logic             force_usr;
        logic             exc_ret;
        logic [CNTW-1:0]  n;
        logic [OFFW-1:0]  off;
        logic [RIW-1:0]   last_reg;
    } seq_st_t;

    seq_st_t st_d, st_q;

    logic [CNTW-1:0]  req_cnt;
    logic [RIW-1:0]   low_idx;
    logic [NREGS-1:0] low_rest;
    logic [OFFW-1:0]  req_span;
    logic [OFFW-1:0]  start_off;
    logic             fire;
    uop_op_e          opc_w;

    lsm_popcnt #(.N(NREGS), .CW(CNTW)) u_cnt (
        .bits_i (req_list),
        .cnt_o  (req_cnt)
    );

    lsm_lowbit #(.N(NREGS), .IW(RIW)) u_low (
        .mask_i (st_q.mask),
        .idx_o  (low_idx),
        .rest_o (low_rest)
    );

    assign req_span  = OFFW'(req_cnt) << 2;
    assign start_off = req_incr ? (req_before ? STEP : '0)
                                : (req_before ? req_span : req_span - STEP);
    assign req_ready = (st_q.ph == PH_IDLE);
    assign uop_valid = (st_q.ph != PH_IDLE);
    assign fire      = uop_valid && uop_ready;
    assign uop_opc   = opc_w;

    always_comb begin
        st_d     = st_q;
        opc_w    = OP_ADDI;
        uop_ra   = '0;
        uop_rb   = '0;
        uop_off  = '0;
        uop_up   = 1'b1;
        uop_usr  = 1'b0;
        uop_ctrl = 1'b0;
        uop_ret  = 1'b0;
        uop_last = 1'b0;
        unique case (st_q.ph)
            PH_IDLE: begin
                if (req_valid) begin
                    st_d.ph        = PH_COPY;
                    st_d.mask      = req_list;
                    st_d.base      = req_base;
                    st_d.ld        = req_load;
                    st_d.incr      = req_incr;
                    st_d.wb        = req_wb;
                    st_d.force_usr = req_user && !req_list[PC_IDX];
                    st_d.exc_ret   = req_user && req_list[PC_IDX];
                    st_d.n         = req_cnt;
                    st_d.off       = start_off;
                    st_d.last_reg  = '0;
                end
            end
            PH_COPY: begin
                opc_w    = OP_ADDI;
                uop_ra   = TMP0;
                uop_rb   = {1'b0, st_q.base};
                uop_last = (st_q.mask == '0);
                if (fire) st_d.ph = (st_q.mask == '0) ? PH_IDLE : PH_MEM;
            end
            PH_MEM: begin
                uop_rb  = TMP0;
                uop_off = st_q.off;
                uop_up  = st_q.incr;
                if (st_q.ld) begin
                    if (st_q.wb && low_rest == '0) begin
                        opc_w  = OP_LOAD;
                        uop_ra = TMP1;
                    end else if (low_idx == PCR && st_q.exc_ret) begin
                        opc_w  = OP_LOADRET;
                        uop_ra = {1'b0, low_idx};
                    end else begin
                        opc_w   = OP_LOAD;
                        uop_ra  = {1'b0, low_idx};
                        uop_usr = st_q.force_usr;
                    end
                end else begin
                    opc_w   = OP_STORE;
                    uop_ra  = {1'b0, low_idx};
                    uop_usr = st_q.force_usr;
                end
                uop_last = (low_rest == '0) && !st_q.wb;
                if (fire) begin
                    st_d.mask     = low_rest;
                    st_d.off      = st_q.incr ? st_q.off + STEP : st_q.off - STEP;
                    st_d.last_reg = low_idx;
                    if (low_rest == '0) st_d.ph = st_q.wb ? PH_WB : PH_IDLE;
                end
            end
            PH_WB: begin
                opc_w    = st_q.incr ? OP_ADDI : OP_SUBI;
                uop_ra   = {1'b0, st_q.base};
                uop_rb   = {1'b0, st_q.base};
                uop_off  = OFFW'(st_q.n) << 2;
                uop_up   = st_q.incr;
                uop_last = !st_q.ld;
                if (fire) st_d.ph = st_q.ld ? PH_MOVE : PH_IDLE;
            end
            PH_MOVE: begin
                uop_rb   = TMP1;
                uop_last = 1'b1;
                if (st_q.exc_ret && st_q.last_reg == PCR) begin
                    opc_w  = OP_MOVRET;
                    uop_ra = {1'b0, PCR};
                end else begin
                    opc_w    = OP_MOV;
                    uop_ra   = {1'b0, st_q.last_reg};
                    uop_usr  = st_q.force_usr;
                    uop_ctrl = (st_q.last_reg == PCR);
                    uop_ret  = (st_q.last_reg == PCR) && (st_q.base == SPR);
                end
                if (fire) st_d.ph = PH_IDLE;
            end
            default: st_d.ph = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q    <= '0;
            st_q.ph <= PH_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    // Observer: set once the base update has been handed over.
    logic wb_seen_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wb_seen_q <= 1'b0;
        end else if (fire && uop_last) begin
            wb_seen_q <= 1'b0;
        end else if (fire && (uop_opc == OP_ADDI || uop_opc == OP_SUBI) && uop_ra != TMP0) begin
            wb_seen_q <= 1'b1;
        end
    end

    p_busy_excl_r1: assert property (@(posedge clk) disable iff (!rst_n)
        uop_valid |-> !req_ready);

    p_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (uop_valid && !uop_ready) |=> (uop_valid && $stable(uop_opc) && $stable(uop_ra)
            && $stable(uop_rb) && $stable(uop_off) && $stable(uop_up) && $stable(uop_usr)
            && $stable(uop_ctrl) && $stable(uop_ret) && $stable(uop_last)));

    p_first_copy_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> (uop_valid && uop_opc == OP_ADDI && uop_ra == TMP0
            && uop_off == '0));

    p_last_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && uop_last) |=> req_ready);

    p_no_mem_after_wb_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (uop_valid && wb_seen_q) |-> !(uop_opc == OP_LOAD || uop_opc == OP_LOADRET
            || uop_opc == OP_STORE));

    p_hint_on_pc_move_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (uop_valid && (uop_ctrl || uop_ret)) |-> (uop_opc == OP_MOV && uop_ctrl
            && uop_ra == {1'b0, PCR}));
endmodule

// File: tb/lsm_uop_seq_test.sv
module lsm_uop_seq_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [15:0] req_list = '0;
    logic [3:0]  req_base = '0;
    logic        req_load = 1'b0, req_incr = 1'b0, req_before = 1'b0;
    logic        req_wb = 1'b0, req_user = 1'b0;
    logic        uop_valid, uop_ready = 1'b0;
    logic [2:0]  uop_opc;
    logic [4:0]  uop_ra, uop_rb;
    logic [6:0]  uop_off;
    logic        uop_up, uop_usr, uop_ctrl, uop_ret, uop_last;

    int checks = 0;
    int fails  = 0;
    int seen   = 0;
    int cycles = 0;
    bit running = 1'b0;
    logic [24:0] expq[$];

    always #10 clk = ~clk;

    lsm_uop_seq uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_list(req_list), .req_base(req_base), .req_load(req_load),
        .req_incr(req_incr), .req_before(req_before), .req_wb(req_wb),
        .req_user(req_user), .uop_valid(uop_valid), .uop_ready(uop_ready),
        .uop_opc(uop_opc), .uop_ra(uop_ra), .uop_rb(uop_rb), .uop_off(uop_off),
        .uop_up(uop_up), .uop_usr(uop_usr), .uop_ctrl(uop_ctrl), .uop_ret(uop_ret),
        .uop_last(uop_last)
    );

    function automatic logic [24:0] pk(int opc, int ra, int rb, int off,
                                       bit up, bit usr, bit ctrl, bit ret, bit last);
        return {3'(opc), 5'(ra), 5'(rb), 7'(off), up, usr, ctrl, ret, last};
    endfunction

    // Reference model: lists the expected micro-ops (R2..R11).
    task automatic build(logic [15:0] lst, int base, bit ld, bit inc, bit bef, bit wb, bit usr);
        int n = 0;
        int k = 0;
        int o;
        int lastreg = 0;
        bit exc = usr && lst[15];
        bit fu  = usr && !lst[15];
        for (int r = 0; r < 16; r++) if (lst[r]) n++;
        expq.push_back(pk(0, 16, base, 0, 1, 0, 0, 0, n == 0));
        if (n == 0) return;
        o = inc ? (bef ? 4 : 0) : (4 * n - (bef ? 0 : 4));
        for (int r = 0; r < 16; r++) begin
            if (lst[r]) begin
                bit lk;
                k++;
                lk = (k == n);
                if (ld) begin
                    if (wb && lk)            expq.push_back(pk(2, 17, 16, o, inc, 0, 0, 0, 0));
                    else if (r == 15 && exc) expq.push_back(pk(3, 15, 16, o, inc, 0, 0, 0, lk && !wb));
                    else                     expq.push_back(pk(2, r, 16, o, inc, fu, 0, 0, lk && !wb));
                end else begin
                    expq.push_back(pk(4, r, 16, o, inc, fu, 0, 0, lk && !wb));
                end
                o = inc ? o + 4 : o - 4;
                lastreg = r;
            end
        end
        if (wb) begin
            expq.push_back(pk(inc ? 0 : 1, base, base, 4 * n, inc, 0, 0, 0, !ld));
            if (ld) begin
                if (lastreg == 15 && exc)
                    expq.push_back(pk(6, 15, 17, 0, 1, 0, 0, 0, 1));
                else
                    expq.push_back(pk(5, lastreg, 17, 0, 1, fu, lastreg == 15,
                                      lastreg == 15 && base == 13, 1));
            end
        end
    endtask

    // Consumer side: random backpressure, per-cycle comparison (R1, R4..R11).
    initial begin
        forever begin
            @(negedge clk);
            if (running) begin
                uop_ready = ($urandom % 4) != 0;
                if (uop_valid) begin
                    logic [24:0] act;
                    act = {uop_opc, uop_ra, uop_rb, uop_off, uop_up, uop_usr,
                           uop_ctrl, uop_ret, uop_last};
                    checks++;
                    if (expq.size() == 0) begin
                        fails++;
                        $display("FAIL R3: extra micro-op act=%h exp=none", act);
                    end else if (act !== expq[0]) begin
                        fails++;
                        $display("FAIL R4-R11 content: act=%h exp=%h", act, expq[0]);
                    end
                    if (req_ready) begin
                        fails++;
                        $display("FAIL R1: req_ready act=1 exp=0 while busy");
                    end
                    if (uop_ready) begin
                        if (expq.size() != 0) void'(expq.pop_front());
                        seen++;
                    end
                end
            end
        end
    end

    task automatic issue(logic [15:0] lst, int base, bit ld, bit inc, bit bef, bit wb, bit usr);
        int n = 0;
        int exp_cnt;
        for (int r = 0; r < 16; r++) if (lst[r]) n++;
        exp_cnt = (n == 0) ? 1 : n + (wb ? (ld ? 2 : 1) : 0) + 1;
        while (!req_ready) @(negedge clk);
        seen = 0;
        build(lst, base, ld, inc, bef, wb, usr);
        req_list = lst; req_base = 4'(base); req_load = ld; req_incr = inc;
        req_before = bef; req_wb = wb; req_user = usr; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        req_list = 16'hFFFF;
        while (expq.size() != 0 || !req_ready) @(negedge clk);
        checks++;
        if (seen != exp_cnt) begin
            fails++;
            $display("FAIL R3/R2: count act=%0d exp=%0d list=%h", seen, exp_cnt, lst);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        checks++;
        if (req_ready !== 1'b0 && uop_valid !== 1'b0) begin
            fails++;
            $display("FAIL R1: in reset ready=%b valid=%b", req_ready, uop_valid);
        end
        rst_n = 1'b1;
        @(negedge clk);
        checks++;
        if (req_ready !== 1'b1 || uop_valid !== 1'b0) begin
            fails++;
            $display("FAIL R1: after reset ready=%b exp 1 valid=%b exp 0", req_ready, uop_valid);
        end
        running = 1'b1;
        issue(16'h0000, 4, 1, 1, 0, 1, 0);  // R2 empty list
        issue(16'h000A, 2, 1, 1, 0, 0, 0);  // R5 inc-after load
        issue(16'h0031, 7, 1, 1, 1, 1, 0);  // R6 R7 R8 inc-before load wb
        issue(16'h00C2, 3, 0, 0, 0, 1, 0);  // R7 store dec-after wb
        issue(16'h0106, 9, 0, 0, 1, 1, 0);  // R5 store dec-before wb
        issue(16'h8003, 13, 1, 1, 0, 1, 1); // R8 exception-return move
        issue(16'h8010, 5, 1, 0, 1, 0, 1);  // R10 load with exception return
        issue(16'h0070, 6, 1, 1, 0, 1, 1);  // R9 user bank load
        issue(16'h0804, 1, 0, 1, 1, 0, 1);  // R9 user bank store
        issue(16'h8002, 13, 1, 1, 0, 1, 0); // R11 return hint
        issue(16'h8100, 5, 1, 1, 0, 1, 0);  // R11 control hint only
        issue(16'hFFFF, 0, 1, 0, 0, 1, 0);  // R3 full list
        issue(16'h0400, 8, 1, 0, 1, 1, 0);  // R6 single register
        for (int t = 0; t < 40; t++) begin
            issue(16'($urandom), int'($urandom % 16), 1'($urandom), 1'($urandom),
                  1'($urandom), 1'($urandom), 1'($urandom));
        end
        running = 1'b0;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 100000) begin
                fails++;
                $display("FAIL watchdog: cycles act=%0d exp<=100000", cycles);
                $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
                $finish;
            end
        end
    end
endmodule